// File: doc/BRIEF.md
# Bit-Serial Adder with Selectable Length

This block adds two operands with a single one-bit full adder and a carry flip-flop. It does not use a full-width ripple adder. A start pulse captures both operands into shift registers and latches the operation length: a byte (8 bits) or a word (32 bits). On each following clock cycle the adder consumes one bit pair, starting from bit 0, and writes one sum bit into the result register.

When the last bit of the chosen length has been processed, the block raises `done_o` for one cycle. It then presents the sum and the carry out of the top processed bit. A byte addition therefore finishes in 8 bit-cycles and a word addition in 32.

The control is a three-state machine:
- IDLE: waiting after reset.
- RUN: one bit per cycle.
- DONE: result just completed.

Its transitions are:
- IDLE→RUN and DONE→RUN on an accepted start.
- RUN→RUN while bits remain.
- RUN→DONE on the last bit.
- DONE→IDLE when no start arrives.

Top module: `bit_serial_adder`

## Requirements
- R1: After reset `busy_o`, `done_o`, `cout_o` and every bit of `sum_o` are 0.
- R2: A start sampled while not busy captures both operands and the length selector, and clears the carry to 0. `busy_o` is 1 from the next cycle.
- R3: With `wide_i`=1 at start, `busy_o` stays 1 for exactly 32 cycles after the start edge. `done_o` rises on the 33rd.
- R4: With `wide_i`=0 at start, `busy_o` stays 1 for exactly 8 cycles after the start edge. `done_o` rises on the 9th.
- R5: In word mode, when `done_o` is 1, `sum_o` equals (A+B) mod 2^32 and `cout_o` is the carry out of bit 31.
- R6: In byte mode, when `done_o` is 1, `sum_o[7:0]` equals (A[7:0]+B[7:0]) mod 256 and `sum_o[31:8]` is 0. `cout_o` is the carry out of bit 7, and operand bits 31..8 have no effect.
- R7: `done_o` is high for exactly one cycle per completed addition and is never high together with `busy_o`.
- R8: A start sampled while busy is ignored. The running addition keeps its operands, length and finish time.
- R9: `sum_o` and `cout_o` hold their values from completion until the next accepted start.
- R10: A start sampled in the `done_o` cycle is accepted, giving back-to-back additions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled on the clock edge |
| wide_i | input | 1 | Length select: 1 = 32-bit word, 0 = 8-bit byte |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| busy_o | output | 1 | Addition in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sum_o | output | 32 | Sum; upper 24 bits are 0 in byte mode |
| cout_o | output | 1 | Carry out of the top processed bit |

## Verification
A bit counter that starts or stops wrong shows up at the ports within one addition. `busy_o` would last a cycle too long or too short, and `done_o` would move by that amount. A carry flip-flop that is not cleared or not updated corrupts the sum the first time a carry or a stale carry matters. That is visible in the `done_o` cycle of the same addition. A bench model that counts the cycles remaining and holds the behavioural sum is compared with `busy_o`, `done_o`, `sum_o` and `cout_o` on every clock. This exposes such faults in the cycle they appear.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } bsa_state_e;

endpackage

// File: rtl/bsa_fulladd.sv
module bsa_fulladd (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);

    logic half_x;

    always_comb begin
        half_x = a_i ^ b_i;
        s_o    = half_x ^ c_i;
        c_o    = (a_i & b_i) | (half_x & c_i);
    end

endmodule

// File: rtl/bsa_opshift.sv
module bsa_opshift #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         step_i,
    input  logic [W-1:0] d_i,
    output logic         lsb_o
);

    logic [W-1:0] q_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_r <= '0;
        end else if (load_i) begin
            q_r <= d_i;
        end else if (step_i) begin
            q_r <= {1'b0, q_r[W-1:1]};
        end
    end

    assign lsb_o = q_r[0];

endmodule

// File: rtl/bsa_ctrl.sv
module bsa_ctrl
    import bsa_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int SHORT_W = 8,
    localparam int IDX_W  = $clog2(DATA_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             wide_i,
    output logic             load_o,
    output logic             step_o,
    output logic             wide_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             busy_o,
    output logic             done_o
);

    localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(DATA_W - 1);
    localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(SHORT_W - 1);

    bsa_state_e       state_r, state_n;
    logic [IDX_W-1:0] idx_r;
    logic [IDX_W-1:0] last_r;
    logic             wide_r;
    logic             at_last;

    assign at_last = (idx_r == last_r);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_r <= ST_IDLE;
        else        state_r <= state_n;
    end

    // Next-state logic
    always_comb begin
        state_n = state_r;
        unique case (state_r)
            ST_IDLE: if (start_i) state_n = ST_RUN;
            ST_RUN:  if (at_last) state_n = ST_DONE;
            ST_DONE: state_n = start_i ? ST_RUN : ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    // Output logic
    always_comb begin
        load_o = 1'b0;
        step_o = 1'b0;
        busy_o = 1'b0;
        done_o = 1'b0;
        unique case (state_r)
            ST_IDLE: load_o = start_i;
            ST_RUN: begin
                step_o = 1'b1;
                busy_o = 1'b1;
            end
            ST_DONE: begin
                load_o = start_i;
                done_o = 1'b1;
            end
            default: ;
        endcase
    end

    // Bit counter and latched length
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_r  <= '0;
            last_r <= LAST_LONG;
            wide_r <= 1'b1;
        end else if (load_o) begin
            idx_r  <= '0;
            last_r <= wide_i ? LAST_LONG : LAST_SHORT;
            wide_r <= wide_i;
        end else if (step_o && !at_last) begin
            idx_r <= idx_r + IDX_W'(1);
        end
    end

    assign idx_o  = idx_r;
    assign wide_o = wide_r;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && !at_last) |=> (busy_o && idx_r == $past(idx_r) + IDX_W'(1))); // R8

    AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && idx_r == '0)); // R2

    AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !$past(load_o)) |-> $stable(last_r)); // R8

endmodule

// File: rtl/bsa_result.sv
module bsa_result #(
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              sbit_i,
    input  logic              cnext_i,
    output logic              carry_o,
    output logic [DATA_W-1:0] sum_o
);

    logic              carry_r;
    logic [DATA_W-1:0] sum_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            carry_r <= 1'b0;
            sum_r   <= '0;
        end else if (load_i) begin
            carry_r <= 1'b0;
            sum_r   <= '0;
        end else if (step_i) begin
            carry_r        <= cnext_i;
            sum_r[idx_i]   <= sbit_i;
        end
    end

    assign carry_o = carry_r;
    assign sum_o   = sum_r;

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i) |=> ($stable(sum_r) && $stable(carry_r))); // R9

    AST_CARRY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (carry_r == 1'b0)); // R2

endmodule

// File: rtl/bit_serial_adder.sv
module bit_serial_adder #(
    parameter int DATA_W  = 32,
    parameter int SHORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              wide_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] sum_o,
    output logic              cout_o
);

    localparam int IDX_W = $clog2(DATA_W);

    logic             load_w, step_w, wide_w;
    logic [IDX_W-1:0] idx_w;
    logic             abit_w, bbit_w, sbit_w, cnext_w, carry_w;

    bsa_ctrl #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .wide_i(wide_i),
        .load_o(load_w), .step_o(step_w), .wide_o(wide_w), .idx_o(idx_w),
        .busy_o(busy_o), .done_o(done_o)
    );

    bsa_opshift #(.W(DATA_W)) u_opa (
        .clk(clk), .rst_n(rst_n), .load_i(load_w), .step_i(step_w),
        .d_i(opa_i), .lsb_o(abit_w)
    );

    bsa_opshift #(.W(DATA_W)) u_opb (
        .clk(clk), .rst_n(rst_n), .load_i(load_w), .step_i(step_w),
        .d_i(opb_i), .lsb_o(bbit_w)
    );

    bsa_fulladd u_fa (
        .a_i(abit_w), .b_i(bbit_w), .c_i(carry_w),
        .s_o(sbit_w), .c_o(cnext_w)
    );

    bsa_result #(.DATA_W(DATA_W)) u_res (
        .clk(clk), .rst_n(rst_n), .load_i(load_w), .step_i(step_w),
        .idx_i(idx_w), .sbit_i(sbit_w), .cnext_i(cnext_w),
        .carry_o(carry_w), .sum_o(sum_o)
    );

    assign cout_o = carry_w;

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o)); // R7

    AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !wide_w) |-> (sum_o[DATA_W-1:SHORT_W] == '0)); // R6

endmodule

// File: tb/bit_serial_adder_tb.sv
module bit_serial_adder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        wide_i = 1'b0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic        busy_o, done_o, cout_o;
    logic [31:0] sum_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    bit_serial_adder dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .wide_i(wide_i),
        .opa_i(opa_i), .opb_i(opb_i), .busy_o(busy_o), .done_o(done_o),
        .sum_o(sum_o), .cout_o(cout_o)
    );

    // Behavioural reference: remaining cycles, result computed by addition
    int          m_rem = 0;
    bit          m_done = 0;
    bit          m_wide = 1;
    logic [31:0] m_sum = '0;
    logic        m_cout = 0;
    logic [31:0] p_sum;
    logic        p_cout;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rem = 0; m_done = 0; m_sum = '0; m_cout = 0;
        end else if (m_rem > 0) begin
            m_rem = m_rem - 1;
            if (m_rem == 0) begin
                m_done = 1; m_sum = p_sum; m_cout = p_cout;
            end
        end else if (start_i) begin
            logic [32:0] w;
            logic [8:0]  b;
            m_wide = wide_i;
            m_rem  = wide_i ? 32 : 8;
            m_done = 0; m_sum = '0; m_cout = 0;
            w = {1'b0, opa_i} + {1'b0, opb_i};
            b = {1'b0, opa_i[7:0]} + {1'b0, opb_i[7:0]};
            if (wide_i) begin p_sum = w[31:0]; p_cout = w[32]; end
            else begin p_sum = {24'h0, b[7:0]}; p_cout = b[8]; end
        end else begin
            m_done = 0;
        end
    end

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at t=%0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            cycles++;
            check(busy_o == (m_rem > 0), m_wide ? "R3" : "R4", busy_o, m_rem > 0);
            check(done_o == m_done, "R7", done_o, m_done);
            if (m_rem == 0) begin
                check(sum_o == m_sum, m_wide ? "R5" : "R6", sum_o, m_sum);
                check(cout_o == m_cout, m_wide ? "R5" : "R6", cout_o, m_cout);
            end
        end
    end

    task automatic launch(input logic [31:0] a, input logic [31:0] b, input bit w);
        @(negedge clk);
        opa_i = a; opb_i = b; wide_i = w; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R2", busy_o, 1);
    endtask

    task automatic wait_done();
        while (!done_o) @(negedge clk);
    endtask

    task automatic add_check(input logic [31:0] a, input logic [31:0] b, input bit w);
        logic [32:0] e;
        launch(a, b, w);
        wait_done();
        e = w ? ({1'b0, a} + {1'b0, b})
              : {24'h0, ({1'b0, a[7:0]} + {1'b0, b[7:0]})};
        if (w) check({cout_o, sum_o} == e, "R5", {cout_o, sum_o}, e);
        else   check({cout_o, sum_o} == {e[8], 24'h0, e[7:0]}, "R6",
                     {cout_o, sum_o}, {e[8], 24'h0, e[7:0]});
    endtask

    initial begin : wd
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1 reset state
        check({busy_o, done_o, cout_o} == 3'b000, "R1", {busy_o, done_o, cout_o}, 0);
        check(sum_o == 32'h0, "R1", sum_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        add_check(32'h0000_0000, 32'h0000_0000, 1'b1);
        add_check(32'hFFFF_FFFF, 32'h0000_0001, 1'b1);
        add_check(32'h1234_5678, 32'h9ABC_DEF0, 1'b1);
        add_check(32'h8000_0000, 32'h8000_0000, 1'b1);
        // R6: upper operand bits must not matter
        add_check(32'hABCD_00FF, 32'h5A5A_0001, 1'b0);
        add_check(32'hFFFF_FF12, 32'hFFFF_FF34, 1'b0);
        add_check(32'h0000_0080, 32'h0000_0080, 1'b0);

        // R3 / R4 latency counted at the ports
        launch(32'h1, 32'h2, 1'b1);
        n = 1;
        while (busy_o) begin @(negedge clk); n++; end
        check(n == 33 && done_o, "R3", n, 33);
        launch(32'h1, 32'h2, 1'b0);
        n = 1;
        while (busy_o) begin @(negedge clk); n++; end
        check(n == 9 && done_o, "R4", n, 9);

        // R8: start while busy ignored
        launch(32'h0000_0011, 32'h0000_0022, 1'b0);
        opa_i = 32'hFFFF_FFFF; opb_i = 32'hFFFF_FFFF; wide_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
        check(sum_o == 32'h33 && cout_o == 1'b0, "R8", sum_o, 32'h33);
        @(negedge clk);
        check(busy_o == 1'b0, "R8", busy_o, 0);

        // R9: result holds while idle, operand inputs changing
        opa_i = 32'h7777_7777; opb_i = 32'h1111_1111;
        repeat (5) @(negedge clk);
        check(sum_o == 32'h33 && !done_o, "R9", sum_o, 32'h33);

        // R10: start in the done cycle is accepted
        launch(32'h0000_00F0, 32'h0000_0020, 1'b0);
        wait_done();
        opa_i = 32'h0001_0000; opb_i = 32'h0002_0000; wide_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R10", busy_o, 1);
        wait_done();
        check(sum_o == 32'h0003_0000, "R10", sum_o, 32'h0003_0000);

        for (int i = 0; i < 20; i++) begin
            add_check($urandom, $urandom, i[0]);
        end

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule